// File: doc/BRIEF.md
# Temporal Grayscale Dithering Table

This block turns a coarse per-component intensity into a single on/off bit per color component. The pattern of that bit changes from frame to frame and from pixel to pixel, so a display that can only switch each component fully on or off still shows intermediate gray levels. Each of the three components (red, green, blue) keeps the top three bits of its input byte as an intensity level. That level, the running frame number and the low bits of the pixel's column and row select one bit from a programmable pattern table. Each component has its own table.

The block sits after any palette stage. Its inputs can come from a palette or straight from pixel memory. Software draws the wanted on/off picture of a 4×4 pixel tile for each of eight successive frames and each intensity level. It then writes those pictures into the table, one 16-bit tile word at a time, through a plain write port. Level 0 is always dark and level 7 is always lit, so the table words for those two levels are don't-cares. A frame-start pulse steps the frame number. Results leave through one register stage.

Top module: `gray_dither_lut`

## Requirements
- R1: The outputs are registered with one clock of latency: `out_valid` in cycle N+1 equals `pix_valid` in cycle N, and `out_r`/`out_g`/`out_b` in cycle N+1 belong to the pixel presented in cycle N.
- R2: Whenever `out_valid` is low, `out_r`, `out_g` and `out_b` are all 0.
- R3: A component whose level (input bits [7:5]) is 000 produces 0, whatever its table holds.
- R4: A component whose level is 111 produces 1, whatever its table holds.
- R5: For levels 001 to 110, the output is bit `{y[1:0], x[1:0]}` (that is, y[1:0]*4 + x[1:0]) of the 16-bit word stored for that component, level and current frame number. Higher position bits have no effect.
- R6: The frame number is a 3-bit counter. It steps by one at each clock edge where `frame_start` is high and wraps from 7 to 0. A pixel presented in the same cycle as `frame_start` uses the frame number from before the step.
- R7: When `wr_en` is high, `wr_data` is stored as the word for component `wr_comp` (0 red, 1 green, 2 blue), level `wr_level` and frame `wr_frame`. A pixel presented in the next cycle already sees the new word. A write with `wr_comp` = 3 changes no table.
- R8: Synchronous reset clears every table word to 0, sets the frame number to 0 and drives `out_valid`, `out_r`, `out_g` and `out_b` to 0.
- R9: Only bits [7:5] of each component input matter. Bits [4:0] have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that steps the frame number |
| pix_valid | input | 1 | Pixel inputs are valid this cycle |
| pix_x | input | POS_W (11) | Pixel column |
| pix_y | input | POS_W (11) | Pixel row |
| pix_r | input | COMP_W (8) | Red component |
| pix_g | input | COMP_W (8) | Green component |
| pix_b | input | COMP_W (8) | Blue component |
| wr_en | input | 1 | Table write strobe |
| wr_comp | input | 2 | Target component: 0 red, 1 green, 2 blue, 3 none |
| wr_level | input | 3 | Target intensity level |
| wr_frame | input | FRAME_W (3) | Target frame number |
| wr_data | input | 16 | 4×4 tile pattern, bit index y*4+x |
| out_valid | output | 1 | Output bits are valid |
| out_r | output | 1 | Dithered red bit |
| out_g | output | 1 | Dithered green bit |
| out_b | output | 1 | Dithered blue bit |

## Verification
The tables are first loaded with a different word for every component, level and frame. A vector table then walks pixels at varied columns, rows and frame advances. A misplaced tile bit, a swapped component or a frame counter that is off by one (including across the 7-to-0 wrap) all produce a wrong bit. Mixed inputs put levels 0 and 7 next to mid levels, and set nonzero low bits, to separate the forced cases and the ignored bits from the table path. Directed cases cover the tables not being selected by `wr_comp` = 3, a write read back in the very next cycle, a pixel that arrives together with `frame_start`, and the idle and reset states.

// File: rtl/gray_dither_pkg.sv
package gray_dither_pkg;

    localparam int LVL_W      = 3;
    localparam int COMP_COUNT = 3;
    localparam int LVL_COUNT  = 1 << LVL_W;

    typedef logic [LVL_W-1:0] level_t;

    typedef enum logic [1:0] {
        COMP_RED   = 2'd0,
        COMP_GREEN = 2'd1,
        COMP_BLUE  = 2'd2,
        COMP_NONE  = 2'd3
    } comp_sel_e;

    typedef struct packed {
        logic                  valid;
        logic [COMP_COUNT-1:0] on;
    } dot_t;

    // Final shade decision: extreme levels override the pattern table.
    function automatic logic shade_bit(input level_t lvl, input logic pattern_bit);
        if (lvl == '0)
            return 1'b0;
        else if (lvl == '1)
            return 1'b1;
        else
            return pattern_bit;
    endfunction

endpackage

// File: rtl/gray_dither_frame_ctr.sv
module gray_dither_frame_ctr #(
    parameter int FRAME_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    output logic [FRAME_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (step)
            count <= count + 1'b1;
    end

endmodule

// File: rtl/gray_dither_bank.sv
module gray_dither_bank
    import gray_dither_pkg::*;
#(
    parameter int FRAME_W   = 3,
    parameter int TILE_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  level_t               w_lvl,
    input  logic [FRAME_W-1:0]   w_frm,
    input  logic [TILE_BITS-1:0] w_data,
    input  level_t               r_lvl,
    input  logic [FRAME_W-1:0]   r_frm,
    output logic [TILE_BITS-1:0] r_word
);

    localparam int ADDR_W = LVL_W + FRAME_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [TILE_BITS-1:0] words [DEPTH];
    logic [ADDR_W-1:0]    w_addr;
    logic [ADDR_W-1:0]    r_addr;

    assign w_addr = {w_lvl, w_frm};
    assign r_addr = {r_lvl, r_frm};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                words[i] <= '0;
        end else if (we) begin
            words[w_addr] <= w_data;
        end
    end

    assign r_word = words[r_addr];

endmodule

// File: rtl/gray_dither_lut.sv
module gray_dither_lut
    import gray_dither_pkg::*;
#(
    parameter int COMP_W  = 8,
    parameter int POS_W   = 11,
    parameter int FRAME_W = 3,
    parameter int TILE_W  = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          frame_start,
    input  logic                          pix_valid,
    input  logic [POS_W-1:0]              pix_x,
    input  logic [POS_W-1:0]              pix_y,
    input  logic [COMP_W-1:0]             pix_r,
    input  logic [COMP_W-1:0]             pix_g,
    input  logic [COMP_W-1:0]             pix_b,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_comp,
    input  logic [LVL_W-1:0]              wr_level,
    input  logic [FRAME_W-1:0]            wr_frame,
    input  logic [(1 << (2*TILE_W))-1:0]  wr_data,
    output logic                          out_valid,
    output logic                          out_r,
    output logic                          out_g,
    output logic                          out_b
);

    localparam int TILE_BITS = 1 << (2 * TILE_W);
    localparam int IDX_W     = 2 * TILE_W;

    logic [FRAME_W-1:0]   frame_num;
    level_t               lvl   [COMP_COUNT];
    logic [TILE_BITS-1:0] word  [COMP_COUNT];
    logic [IDX_W-1:0]     tidx;
    dot_t                 dot_d;
    dot_t                 dot_q;

    gray_dither_frame_ctr #(
        .FRAME_W (FRAME_W)
    ) u_frame (
        .clk   (clk),
        .rst   (rst),
        .step  (frame_start),
        .count (frame_num)
    );

    assign lvl[COMP_RED]   = pix_r[COMP_W-1 -: LVL_W];
    assign lvl[COMP_GREEN] = pix_g[COMP_W-1 -: LVL_W];
    assign lvl[COMP_BLUE]  = pix_b[COMP_W-1 -: LVL_W];

    assign tidx = {pix_y[TILE_W-1:0], pix_x[TILE_W-1:0]};

    for (genvar c = 0; c < COMP_COUNT; c++) begin : g_comp
        logic we_c;
        assign we_c = wr_en && (wr_comp == 2'(c));

        gray_dither_bank #(
            .FRAME_W   (FRAME_W),
            .TILE_BITS (TILE_BITS)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .we     (we_c),
            .w_lvl  (wr_level),
            .w_frm  (wr_frame),
            .w_data (wr_data),
            .r_lvl  (lvl[c]),
            .r_frm  (frame_num),
            .r_word (word[c])
        );

        assign dot_d.on[c] = pix_valid && shade_bit(lvl[c], word[c][tidx]);
    end

    assign dot_d.valid = pix_valid;

    always_ff @(posedge clk) begin
        if (rst)
            dot_q <= '0;
        else
            dot_q <= dot_d;
    end

    assign out_valid = dot_q.valid;
    assign out_r     = dot_q.on[COMP_RED];
    assign out_g     = dot_q.on[COMP_GREEN];
    assign out_b     = dot_q.on[COMP_BLUE];

endmodule

// File: rtl/gray_dither_lut_chk.sv
module gray_dither_lut_chk #(
    parameter int COMP_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              pix_valid,
    input logic [COMP_W-1:0] pix_r,
    input logic [COMP_W-1:0] pix_g,
    input logic [COMP_W-1:0] pix_b,
    input logic              out_valid,
    input logic              out_r,
    input logic              out_g,
    input logic              out_b
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> out_valid); // R1
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !out_valid); // R1
    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(out_r || out_g || out_b)); // R2
    AST_BLACK_RED: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_r[COMP_W-1 -: 3] == 3'b000) |=> !out_r); // R3
    AST_BLACK_GREEN: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_g[COMP_W-1 -: 3] == 3'b000) |=> !out_g); // R3
    AST_BLACK_BLUE: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_b[COMP_W-1 -: 3] == 3'b000) |=> !out_b); // R3
    AST_WHITE_RED: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_r[COMP_W-1 -: 3] == 3'b111) |=> out_r); // R4
    AST_WHITE_GREEN: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_g[COMP_W-1 -: 3] == 3'b111) |=> out_g); // R4
    AST_WHITE_BLUE: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_b[COMP_W-1 -: 3] == 3'b111) |=> out_b); // R4
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !(out_valid || out_r || out_g || out_b)); // R8

endmodule

bind gray_dither_lut gray_dither_lut_chk #(.COMP_W(COMP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pix_valid (pix_valid),
    .pix_r     (pix_r),
    .pix_g     (pix_g),
    .pix_b     (pix_b),
    .out_valid (out_valid),
    .out_r     (out_r),
    .out_g     (out_g),
    .out_b     (out_b)
);

// File: tb/gray_dither_lut_tb.sv
module gray_dither_lut_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic        pix_valid = 1'b0;
    logic [10:0] pix_x = '0;
    logic [10:0] pix_y = '0;
    logic [7:0]  pix_r = '0;
    logic [7:0]  pix_g = '0;
    logic [7:0]  pix_b = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_comp = '0;
    logic [2:0]  wr_level = '0;
    logic [2:0]  wr_frame = '0;
    logic [15:0] wr_data = '0;
    logic        out_valid, out_r, out_g, out_b;

    int checks = 0;
    int fails  = 0;
    logic [2:0]  fcount = '0;
    logic [15:0] tab [3][8][8];

    always #4 clk = ~clk;   // 125 MHz

    gray_dither_lut u_dut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .pix_valid(pix_valid),
        .pix_x(pix_x), .pix_y(pix_y), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .wr_en(wr_en), .wr_comp(wr_comp), .wr_level(wr_level), .wr_frame(wr_frame),
        .wr_data(wr_data), .out_valid(out_valid), .out_r(out_r), .out_g(out_g),
        .out_b(out_b)
    );

    // {adv[43:40], x[39:32], y[31:24], r[23:16], g[15:8], b[7:0]}
    localparam logic [43:0] VEC [12] = '{
        44'h0_00_00_20_40_60,
        44'h1_01_02_7F_9F_BF,
        44'h0_05_06_C0_E0_A0,
        44'h3_FF_FF_33_55_77,
        44'h2_12_34_88_A8_C8,
        44'h4_08_0B_E1_C1_21,
        44'h0_03_00_00_FF_40,
        44'h1_02_03_5A_3C_9E,
        44'h5_0E_0D_D4_B2_6A,
        44'h0_0F_0F_1F_E0_C0,
        44'h7_07_04_A5_A5_A5,
        44'h8_09_01_66_99_CC
    };

    function automatic logic [15:0] pat(int c, int l, int f);
        return 16'hA5C3 ^ (16'(l) * 16'h1357) ^ (16'(f) * 16'h0F1E) ^ (16'(c) * 16'h3C3C);
    endfunction

    function automatic logic model_bit(int c, logic [7:0] v, logic [10:0] x,
                                       logic [10:0] y, logic [2:0] f);
        logic [2:0] l;
        l = v[7:5];
        if (l == 3'd0) return 1'b0;
        if (l == 3'd7) return 1'b1;
        return tab[c][l][f][{y[1:0], x[1:0]}];
    endfunction

    task automatic check4(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {valid,r,g,b} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_write(int c, int l, int f, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_comp = 2'(c); wr_level = 3'(l); wr_frame = 3'(f); wr_data = d;
        if (c < 3) tab[c][l][f] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        fcount = fcount + 3'd1;
    endtask

    // Present one pixel; optionally raise frame_start in the same cycle.
    task automatic try_pix(string tag, logic [7:0] r, logic [7:0] g, logic [7:0] b,
                           logic [10:0] x, logic [10:0] y, logic with_frame);
        logic [3:0] exp;
        @(negedge clk);
        pix_valid = 1'b1; pix_r = r; pix_g = g; pix_b = b; pix_x = x; pix_y = y;
        frame_start = with_frame;
        exp = {1'b1, model_bit(0, r, x, y, fcount), model_bit(1, g, x, y, fcount),
               model_bit(2, b, x, y, fcount)};
        @(negedge clk);
        frame_start = 1'b0;
        if (with_frame) fcount = fcount + 3'd1;
        check4(tag, {out_valid, out_r, out_g, out_b}, exp);
        pix_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        fcount = '0;
        for (int c = 0; c < 3; c++)
            for (int l = 0; l < 8; l++)
                for (int f = 0; f < 8; f++)
                    tab[c][l][f] = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 3; c++)
            for (int l = 0; l < 8; l++)
                for (int f = 0; f < 8; f++)
                    tab[c][l][f] = '0;
        repeat (3) @(negedge clk);
        // R8: outputs low during reset
        check4("R8 reset state", {out_valid, out_r, out_g, out_b}, 4'b0000);
        rst = 1'b0;

        // R2: idle input keeps all outputs low
        @(negedge clk);
        pix_r = 8'hFF; pix_g = 8'hE0; pix_b = 8'h60;
        @(negedge clk);
        check4("R2 idle", {out_valid, out_r, out_g, out_b}, 4'b0000);

        // R7: load every mid-level pattern
        for (int c = 0; c < 3; c++)
            for (int l = 1; l < 7; l++)
                for (int f = 0; f < 8; f++)
                    do_write(c, l, f, pat(c, l, f));

        // R5 R6 R9: vector walk
        for (int i = 0; i < 12; i++) begin
            for (int k = 0; k < int'(VEC[i][43:40]); k++) pulse_frame();
            try_pix("R5 R6 R9 vector", VEC[i][23:16], VEC[i][15:8], VEC[i][7:0],
                    11'(VEC[i][39:32]), 11'(VEC[i][31:24]), 1'b0);
        end

        // R3: level 0 stays dark even with an all-ones word
        do_write(0, 0, fcount, 16'hFFFF);
        do_write(1, 0, fcount, 16'hFFFF);
        do_write(2, 0, fcount, 16'hFFFF);
        try_pix("R3 level zero", 8'h1F, 8'h00, 8'h0A, 11'd1, 11'd2, 1'b0);
        // R4: level 7 stays lit even with an all-zeros word
        do_write(0, 7, fcount, 16'h0000);
        do_write(1, 7, fcount, 16'h0000);
        do_write(2, 7, fcount, 16'h0000);
        try_pix("R4 level seven", 8'hE0, 8'hFF, 8'hF3, 11'd3, 11'd3, 1'b0);

        // R7: component select 3 writes nothing
        for (int p = 0; p < 4; p++) begin
            do_write(3, 3, fcount, ~tab[0][3][fcount]);
            try_pix("R7 no-target write", 8'h60, 8'h60, 8'h60, 11'(p), 11'(3 - p), 1'b0);
        end

        // R7: write is visible to the very next pixel
        do_write(1, 4, fcount, 16'h0001 << 6);
        try_pix("R7 next-cycle read", 8'h00, 8'h80, 8'h00, 11'd2, 11'd1, 1'b0);
        do_write(1, 4, fcount, ~(16'h0001 << 6));
        try_pix("R7 next-cycle read inverse", 8'h00, 8'h80, 8'h00, 11'd6, 11'd5, 1'b0);

        // R6: pixel coinciding with frame_start uses the old frame
        do_write(0, 2, fcount, 16'hFFFF);
        do_write(0, 2, fcount + 3'd1, 16'h0000);
        try_pix("R6 same-cycle frame step", 8'h40, 8'h00, 8'h00, 11'd0, 11'd0, 1'b1);
        try_pix("R6 after frame step", 8'h40, 8'h00, 8'h00, 11'd0, 11'd0, 1'b0);

        // R8: reset mid-run clears tables and frame number
        pulse_frame();
        pulse_frame();
        do_reset();
        check4("R8 outputs after reset", {out_valid, out_r, out_g, out_b}, 4'b0000);
        try_pix("R8 tables cleared", 8'h60, 8'h80, 8'hA0, 11'd1, 11'd1, 1'b0);
        do_write(0, 3, 0, 16'hFFFF);
        try_pix("R8 frame number zero", 8'h60, 8'h00, 8'h00, 11'd2, 11'd2, 1'b0);

        // R1: a lone valid cycle gives exactly one valid output cycle
        @(negedge clk);
        check4("R1 valid drops", {out_valid, out_r, out_g, out_b}, 4'b0000);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule